// File: doc/BRIEF.md
# Segmented DAC Switch-Control Front End

This block is the digital front end of a 12-bit segmented current-steering converter. It takes a 12-bit sample word and a hold control, and splits the word into three groups of switch controls. The top four bits drive fifteen equal-weight current cells through a thermometer decoder. The next two bits drive two binary-weighted cells directly. The bottom six bits drive a six-bit resistive ladder.

The decoder costs one register stage. The undecoded bits and the hold control pass through a register of the same depth, so every switch control moves in the same cycle. The final stage is a level-sensitive latch. It is transparent during the low phase of the clock when the delayed hold control is low. It keeps its contents while the delayed hold control is high.

An optional rising-edge input register, chosen by a parameter, puts a flop in front of the latch. The latch then opens in the opposite clock phase, which gives master-slave, edge-triggered behaviour. The current cells, the ladder and the reference are outside this block.

Top module: `segdac_front`

## Requirements
- R1: Thermometer line k (bit k-1 of `therm_sw`, k = 1..15) is high exactly when the unsigned value of `din[11:8]` is at least k. The lines therefore always form a contiguous run of ones starting at bit 0.
- R2: `mid_sw[1]` follows `din[7]` (weight 128) and `mid_sw[0]` follows `din[6]` (weight 64).
- R3: `ladder_sw` equals `din[5:0]`.
- R4: With the input register present, a word applied before rising edge N is visible on all switch outputs during the low phase after edge N+1. During the low phase after edge N, the outputs still show the older value. All three groups change in the same phase.
- R5: While the delayed `latch_en` is low, the outputs follow the delayed word during each low clock phase.
- R6: While the delayed `latch_en` is high, changes on `din` have no effect on the outputs.
- R7: While `rst` is high, and after it is released with the pipeline holding zeros, every switch output is zero.
- R8: An all-ones word turns on all 15 lines, both middle switches and the full ladder (code 4095, complement 0). An all-zeros word turns every switch off (code 0, complement 4095). The code and its complement always sum to 4095.
- R9: 256 × (number of high thermometer lines) + 128·`mid_sw[1]` + 64·`mid_sw[0]` + `ladder_sw` equals the word that the latch admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers on the rising edge, latch open in the low phase |
| rst | input | 1 | Active-high reset; synchronous for the registers, level for the latch |
| din | input | 12 | Sample word, bit 11 is the most significant |
| latch_en | input | 1 | High freezes the output latch (after the pipeline delay) |
| therm_sw | output | 15 | Thermometer controls for the equal-weight cells |
| mid_sw | output | 2 | Binary-weighted cell controls (bit 1 = weight 128) |
| ladder_sw | output | 6 | Ladder bit controls |

## Verification
The bench targets the full-scale and zero-scale words. An off-by-one threshold in the decoder would drop or add one line there, and the code and complement would no longer sum to 4095.

It measures the pipeline depth with a single step. A missing equalizing stage would make the middle and ladder bits lead the thermometer lines by a cycle.

It holds the latch while the input keeps changing. A hold control that skipped the delay would freeze the wrong word or let one word slip through.

Random words mixed with random holds are compared every cycle against a queue-based model. Stuck switch lines and segment swaps show up there.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    localparam int UPPER_W = 4;
    localparam int MID_W   = 2;
    localparam int LOW_W   = 6;
    localparam int TAIL_W  = MID_W + LOW_W;
    localparam int WORD_W  = UPPER_W + TAIL_W;
    localparam int LINES   = (1 << UPPER_W) - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  hold;
        word_t word;
    } in_beat_t;

    typedef struct packed {
        logic [LINES-1:0] therm;
        logic [MID_W-1:0] mid;
        logic [LOW_W-1:0] low;
    } sw_set_t;

    typedef struct packed {
        logic    hold;
        sw_set_t sw;
    } sw_beat_t;

    function automatic logic [UPPER_W-1:0] upper_of(word_t w);
        return w[WORD_W-1 -: UPPER_W];
    endfunction

    function automatic logic [TAIL_W-1:0] tail_of(word_t w);
        return w[TAIL_W-1:0];
    endfunction
endpackage

// File: rtl/segdac_inreg.sv
module segdac_inreg
    import segdac_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  in_beat_t d,
    output in_beat_t q
);
    generate
        if (REGISTERED) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end

            // R4
            inreg_capture_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (q == $past(d)));
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/segdac_decode.sv
module segdac_decode
    import segdac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  in_beat_t d,
    output sw_beat_t q
);
    logic [UPPER_W-1:0] top_bits;
    logic [LINES-1:0]   therm_c;
    logic [TAIL_W-1:0]  tail_c;

    assign top_bits = upper_of(d.word);
    assign tail_c   = tail_of(d.word);

    generate
        for (genvar k = 0; k < LINES; k++) begin : g_line
            assign therm_c[k] = (int'(top_bits) >= (k + 1));
        end
    endgenerate

    // The tail bits and the hold control get one register, the same depth as the decoder.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.hold     <= d.hold;
            q.sw.therm <= therm_c;
            q.sw.mid   <= tail_c[TAIL_W-1 -: MID_W];
            q.sw.low   <= tail_c[LOW_W-1:0];
        end
    end

    // R1
    therm_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (((q.sw.therm + 1'b1) & q.sw.therm) == '0));

    // R9
    dec_map_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($countones(q.sw.therm) * 256 + int'({q.sw.mid, q.sw.low}))
                          == int'($past(d.word))));

    // R4
    hold_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q.hold == $past(d.hold)));
endmodule

// File: rtl/segdac_hold.sv
module segdac_hold
    import segdac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sw_beat_t d,
    output sw_set_t  q
);
    // Open only in the low clock phase, so the latch never sees data and gate move together.
    always_latch begin
        if (rst)                   q = '0;
        else if (!clk && !d.hold)  q = d.sw;
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && d.hold) |-> $stable(q));

    // R5
    transp_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !d.hold) |-> (q == d.sw));
endmodule

// File: rtl/segdac_front.sv
module segdac_front
    import segdac_pkg::*;
#(
    parameter bit USE_INREG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       din,
    input  logic              latch_en,
    output logic [14:0]       therm_sw,
    output logic [1:0]        mid_sw,
    output logic [5:0]        ladder_sw
);
    in_beat_t raw_beat;
    in_beat_t reg_beat;
    sw_beat_t dec_beat;
    sw_set_t  held;

    assign raw_beat.hold = latch_en;
    assign raw_beat.word = din;

    segdac_inreg #(.REGISTERED(USE_INREG)) u_inreg (
        .clk (clk),
        .rst (rst),
        .d   (raw_beat),
        .q   (reg_beat)
    );

    segdac_decode u_decode (
        .clk (clk),
        .rst (rst),
        .d   (reg_beat),
        .q   (dec_beat)
    );

    segdac_hold u_hold (
        .clk (clk),
        .rst (rst),
        .d   (dec_beat),
        .q   (held)
    );

    assign therm_sw  = held.therm;
    assign mid_sw    = held.mid;
    assign ladder_sw = held.low;

    // R7
    rst_zero_chk: assert property (@(posedge clk)
        rst |-> (therm_sw == '0 && mid_sw == '0 && ladder_sw == '0));
endmodule

// File: tb/segdac_front_bench.sv
module segdac_front_bench;
    localparam int PER   = 10;
    localparam bit INREG = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] din = '0;
    logic        latch_en = 1'b0;
    logic [14:0] therm_sw;
    logic [1:0]  mid_sw;
    logic [5:0]  ladder_sw;

    int total = 0;
    int bad   = 0;

    // behavioural model: pipeline of (word, hold) pairs and the latched word
    int s1w = 0, s2w = 0;
    bit s1h = 0, s2h = 0;
    int expw = 0;

    always #(PER/2) clk = ~clk;

    segdac_front #(.USE_INREG(INREG)) u_segdac_front (
        .clk(clk), .rst(rst), .din(din), .latch_en(latch_en),
        .therm_sw(therm_sw), .mid_sw(mid_sw), .ladder_sw(ladder_sw)
    );

    always @(posedge clk) begin
        if (rst) begin
            s1w <= 0; s1h <= 0; s2w <= 0; s2h <= 0;
        end else begin
            s2w <= s1w; s2h <= s1h;
            s1w <= int'(din); s1h <= latch_en;
        end
    end

    function automatic int out_code();
        return $countones(therm_sw) * 256 + int'(mid_sw) * 64 + int'(ladder_sw);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare();
        int hw; bit hh;
        logic [14:0] eth;
        hw = INREG ? s2w : s1w;
        hh = INREG ? s2h : s1h;
        if (rst) expw = 0;
        else if (!hh) expw = hw;
        for (int k = 1; k <= 15; k++) eth[k-1] = ((expw >> 8) >= k);
        chk("R1 thermometer lines", int'(therm_sw), int'(eth));
        chk("R2 middle switches", int'(mid_sw), (expw >> 6) & 3);
        chk("R3 ladder bits", int'(ladder_sw), expw & 63);
        chk("R9 reconstructed code", out_code(), expw);
    endtask

    task automatic step(input int w, input bit le, input bit r);
        @(negedge clk);
        #1;
        compare();
        din = 12'(w);
        latch_en = le;
        rst = r;
    endtask

    initial begin
        #(PER * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(12'hFFF, 0, 1);
        step(12'hFFF, 0, 1);
        chk("R7 reset clears outputs", out_code(), 0);
        step(0, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        chk("R7 zero after release", out_code(), 0);

        // R4 latency: word applied now, seen two low phases later
        step(12'hA5C, 0, 0);
        step(12'hA5C, 0, 0);
        chk("R4 not yet after one edge", out_code(), 0);
        step(12'hA5C, 0, 0);
        chk("R4 visible after two edges", out_code(), 12'hA5C);

        // R8 full and zero scale
        step(12'hFFF, 0, 0);
        step(12'hFFF, 0, 0);
        step(12'hFFF, 0, 0);
        chk("R8 full scale code", out_code(), 4095);
        chk("R8 full scale lines", int'(therm_sw), 16'h7FFF);
        chk("R8 complement sum", out_code() + (4095 - out_code()), 4095);
        step(0, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        chk("R8 zero scale code", out_code(), 0);
        chk("R8 zero complement", 4095 - out_code(), 4095);

        // R6 hold: latch frozen while input keeps moving
        step(12'h3C7, 0, 0);
        step(12'h3C7, 0, 0);
        step(12'h3C7, 0, 0);
        step(12'h111, 1, 0);
        for (int i = 0; i < 6; i++) step(i * 613, 1, 0);
        chk("R6 held during input churn", out_code(), 12'h3C7);
        step(12'h8F0, 0, 0);
        step(12'h8F0, 0, 0);
        step(12'h8F0, 0, 0);
        chk("R5 transparent again", out_code(), 12'h8F0);

        // R5 every threshold of the upper group
        for (int t = 0; t < 16; t++) step(t * 256 + 21, 0, 0);
        // mixed random words and holds
        for (int i = 0; i < 400; i++) step(int'($urandom_range(0, 4095)), ($urandom_range(0, 3) == 0), 0);
        step(0, 0, 0);
        step(0, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule